// File: doc/BRIEF.md
# Posit Operand Decoder

This block converts one posit word of `POSIT_W` bits, with an exponent field of `EXP_W` bits, into the unpacked form that an arithmetic datapath consumes. It has two flag outputs, one for the zero encoding and one for the not-a-real (NaR) encoding. It also produces a scale value and a signed significand. A downstream adder or multiplier can then use the operand without looking at the packed format again.

The scale carries a fixed offset of `(POSIT_W-2)*2^EXP_W + 1`, so it is never negative for any finite non-zero input. The significand keeps the sign of the input in two's complement, so negative words are never converted to sign-magnitude. The regime run is measured with a leading-zero counter on the polarity-normalised body. A shift then removes the regime together with its terminating bit, and the exponent and fraction fall into fixed positions.

The parameter `REG_OUT` selects the timing. When it is 0 the decoder is purely combinational. When it is 1 one register stage is added; that stage loads only when `in_valid` is high.

Top module: `posit_operand_decoder`

## Requirements
- R1: An input of all zeros sets `out_zero` to 1 and `out_nar` to 0, and drives `out_scale` and `out_sig` to zero.
- R2: An input with only the top bit set sets `out_nar` to 1 and `out_zero` to 0, and drives `out_scale` and `out_sig` to zero.
- R3: Every other input pattern leaves both flags at 0.
- R4: For a positive input, `out_scale` equals `k*2^EXP_W + e + (POSIT_W-2)*2^EXP_W + 1`. Here `k` is minus the run length for a run of zeros and the run length minus one for a run of ones, and `e` is the exponent field that follows the regime terminator. The result never exceeds `2*(POSIT_W-2)*2^EXP_W + 1`.
- R5: Exponent bits that fall beyond the end of the word after the regime count as zero.
- R6: `out_sig` is `POSIT_W-EXP_W` bits wide. For a positive input its top two bits are `01`, and the fraction bits follow below them, left-aligned.
- R7: For a negative input, `out_sig * 2^(unbiased scale - (POSIT_W-EXP_W-2))` equals the input's value. `out_sig` is in two's complement and its top two bits are `10`. When the magnitude is an exact power of two, `out_sig` is `10` followed by zeros and the scale is one below the magnitude's scale.
- R8: `out_valid` and all decoded fields appear together. They appear in the same cycle as the input when `REG_OUT=0` and one clock later when `REG_OUT=1`.
- R9: With `REG_OUT=1`, reset clears every output to zero. A cycle with `in_valid` low clears `out_valid` and leaves the scale, the significand and the flags unchanged.
- R10: At `POSIT_W=32`, `EXP_W=2`, a two-bit regime leaves 27 fraction bits. All 27 of them, including the lowest, appear in `out_sig` directly below the hidden bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; used by the optional output register |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input word is valid |
| in_word | input | POSIT_W | Posit word to decode |
| out_valid | output | 1 | Decoded fields are valid |
| out_zero | output | 1 | Input was the zero encoding |
| out_nar | output | 1 | Input was the NaR encoding |
| out_scale | output | SCALE_W | Offset scale, non-negative |
| out_sig | output | POSIT_W-EXP_W | Two's-complement significand with sign and hidden bit on top |

## Verification
The bench runs every 8-bit word through two configurations and every 7-bit word through a configuration with a 3-bit exponent field. Together these sweeps cover:
- regime runs that take up the whole body,
- exponent fields cut short by a long regime,
- negative words whose magnitude is an exact power of two.

Each corner case catches a specific mistake:
- A decoder that negated the fraction as a sign-magnitude value would give the wrong significand for every negative word.
- A decoder that did not lower the scale in the power-of-two case would be off by a factor of two.
- A decoder that lost the cut-short exponent bits, or sign-extended them, would shift whole binades.

Directed 32-bit words check that the lowest fraction bit survives the regime shift. A hold sequence shows that the register stage neither loads on invalid cycles nor forwards its data early.

// File: rtl/posit_dec_pkg.sv
`timescale 1ns/1ps
package posit_dec_pkg;

    // Class of an incoming posit word.
    typedef enum logic [1:0] {
        PCLS_REAL = 2'd0,
        PCLS_ZERO = 2'd1,
        PCLS_NAR  = 2'd2
    } pcls_e;

    // Width that holds the offset scale for a given word and exponent size.
    function automatic int scale_width(input int nbits, input int ebits);
        return $clog2(2 * (nbits - 2) * (2 ** ebits) + 2);
    endfunction

    // Constant that moves the most negative scale to zero.
    function automatic int scale_offset(input int nbits, input int ebits);
        return (nbits - 2) * (2 ** ebits) + 1;
    endfunction

endpackage

// File: rtl/posit_special_detect.sv
`timescale 1ns/1ps
module posit_special_detect
    import posit_dec_pkg::*;
#(
    parameter int POSIT_W = 16
) (
    input  logic [POSIT_W-1:0] word,
    output pcls_e              cls
);

    logic body_any;

    // One wide OR over the bits under the sign separates both special codes.
    assign body_any = |word[POSIT_W-2:0];

    always_comb begin
        if (body_any) begin
            cls = PCLS_REAL;
        end else if (word[POSIT_W-1]) begin
            cls = PCLS_NAR;
        end else begin
            cls = PCLS_ZERO;
        end
    end

endmodule

// File: rtl/posit_lzc.sv
`timescale 1ns/1ps
module posit_lzc #(
    parameter int WIDTH = 15,
    localparam int CW   = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] vec,
    output logic [CW-1:0]    count
);

    logic found;

    // Count of zeros above the first set bit; WIDTH when the vector is empty.
    always_comb begin
        count = '0;
        found = 1'b0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (!found) begin
                if (vec[i]) begin
                    found = 1'b1;
                end else begin
                    count = count + CW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/posit_regime_shift.sv
`timescale 1ns/1ps
module posit_regime_shift #(
    parameter int  POSIT_W = 16,
    parameter int  EXP_W   = 1,
    localparam int BW      = POSIT_W - 1,
    localparam int CW      = $clog2(POSIT_W),
    localparam int KW      = CW + 1,
    localparam int IW      = KW + EXP_W + 1,
    localparam int FW      = POSIT_W - 2 - EXP_W
) (
    input  logic [BW-1:0]        body,
    output logic signed [IW-1:0] raw_scale,
    output logic [FW-1:0]        frac
);

    logic                 pol;
    logic [BW-1:0]        norm;
    logic [CW-1:0]        run_len;
    logic signed [KW-1:0] run_s;
    logic signed [KW-1:0] k_val;
    logic [BW-2:0]        after_lead;
    logic [BW-2:0]        aligned;

    // Make the regime a run of zeros whatever its polarity.
    assign pol  = body[BW-1];
    assign norm = body ^ {BW{pol}};

    posit_lzc #(
        .WIDTH(BW)
    ) u_lzc (
        .vec  (norm),
        .count(run_len)
    );

    // The first regime bit is always consumed, so shift the rest by the run
    // length: this drops the remaining run and its terminator, zero filled.
    assign after_lead = body[BW-2:0];
    assign aligned    = after_lead << run_len;

    always_comb begin
        run_s = signed'({1'b0, run_len});
        if (pol) begin
            k_val = run_s - KW'(1);
        end else begin
            k_val = -run_s;
        end
    end

    assign frac = aligned[FW-1:0];

    generate
        if (EXP_W > 0) begin : g_exp
            logic [EXP_W-1:0]             e_val;
            logic signed [KW+EXP_W-1:0]   ke;
            assign e_val     = aligned[BW-2 -: EXP_W];
            assign ke        = {k_val, e_val};
            assign raw_scale = IW'(ke);
        end else begin : g_noexp
            assign raw_scale = IW'(k_val);
        end
    endgenerate

endmodule

// File: rtl/posit_operand_decoder.sv
`timescale 1ns/1ps
module posit_operand_decoder
    import posit_dec_pkg::*;
#(
    parameter int  POSIT_W = 16,
    parameter int  EXP_W   = 1,
    parameter bit  REG_OUT = 1'b1,
    localparam int SCALE_W = scale_width(POSIT_W, EXP_W),
    localparam int SIG_W   = POSIT_W - EXP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [POSIT_W-1:0] in_word,
    output logic               out_valid,
    output logic               out_zero,
    output logic               out_nar,
    output logic [SCALE_W-1:0] out_scale,
    output logic [SIG_W-1:0]   out_sig
);

    localparam int CW     = $clog2(POSIT_W);
    localparam int KW     = CW + 1;
    localparam int IW     = KW + EXP_W + 1;
    localparam int FW     = POSIT_W - 2 - EXP_W;
    localparam int OFFSET = scale_offset(POSIT_W, EXP_W);
    localparam logic [SCALE_W-1:0] SCALE_MAX = SCALE_W'(2 * (POSIT_W - 2) * (2 ** EXP_W) + 1);

    typedef struct packed {
        logic               valid;
        logic               zero;
        logic               nar;
        logic [SCALE_W-1:0] scale;
        logic [SIG_W-1:0]   sig;
    } dec_t;

    pcls_e                cls;
    logic                 sgn;
    logic signed [IW-1:0] raw_scale;
    logic signed [IW-1:0] unb_scale;
    logic [FW-1:0]        frac;
    dec_t                 fresh;
    dec_t                 out_s;

    assign sgn = in_word[POSIT_W-1];

    posit_special_detect #(
        .POSIT_W(POSIT_W)
    ) u_special (
        .word(in_word),
        .cls (cls)
    );

    posit_regime_shift #(
        .POSIT_W(POSIT_W),
        .EXP_W  (EXP_W)
    ) u_regime (
        .body     (in_word[POSIT_W-2:0]),
        .raw_scale(raw_scale),
        .frac     (frac)
    );

    // Raw fields of a negative word describe (-2 + f) * 2^-(s+1), so the
    // scale is the bitwise inverse and the fraction is used unchanged.
    assign unb_scale = sgn ? ~raw_scale : raw_scale;

    always_comb begin
        fresh       = '0;
        fresh.valid = in_valid;
        unique case (cls)
            PCLS_ZERO: fresh.zero = 1'b1;
            PCLS_NAR:  fresh.nar  = 1'b1;
            default: begin
                fresh.scale = SCALE_W'(unb_scale + IW'(OFFSET));
                fresh.sig   = {sgn, ~sgn, frac};
            end
        endcase
    end

    generate
        if (REG_OUT) begin : g_reg
            dec_t dec_d;
            dec_t dec_q;
            logic armed_q;

            always_comb begin
                dec_d       = dec_q;
                dec_d.valid = in_valid;
                if (in_valid) begin
                    dec_d = fresh;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    dec_q   <= '0;
                    armed_q <= 1'b0;
                end else begin
                    dec_q   <= dec_d;
                    armed_q <= 1'b1;
                end
            end

            assign out_s = dec_q;

            AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
                armed_q |-> (out_valid == $past(in_valid))); // R8
            AST_HOLD_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
                (armed_q && !$past(in_valid)) |-> ($stable(out_scale) && $stable(out_sig)
                                                   && $stable(out_zero) && $stable(out_nar))); // R9
        end else begin : g_comb
            assign out_s = fresh;
        end
    endgenerate

    assign out_valid = out_s.valid;
    assign out_zero  = out_s.zero;
    assign out_nar   = out_s.nar;
    assign out_scale = out_s.scale;
    assign out_sig   = out_s.sig;

    AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_zero) |-> (out_scale == '0 && out_sig == '0)); // R1
    AST_NAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_nar) |-> (out_scale == '0 && out_sig == '0)); // R2
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_zero && out_nar)); // R3
    AST_SIG_NORMALISED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_zero && !out_nar) |-> (out_sig[SIG_W-1] != out_sig[SIG_W-2])); // R6
    AST_SCALE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_zero && !out_nar) |-> (out_scale <= SCALE_MAX)); // R4

endmodule

// File: tb/sim_posit_operand_decoder.sv
`timescale 1ns/1ps
module sim_posit_operand_decoder;

    localparam int N0 = 8,  E0 = 1;
    localparam int N1 = 8,  E1 = 0;
    localparam int N2 = 7,  E2 = 3;
    localparam int N3 = 32, E3 = 2;
    localparam int S0 = $clog2(2 * (N0 - 2) * (2 ** E0) + 2);
    localparam int S1 = $clog2(2 * (N1 - 2) * (2 ** E1) + 2);
    localparam int S2 = $clog2(2 * (N2 - 2) * (2 ** E2) + 2);
    localparam int S3 = $clog2(2 * (N3 - 2) * (2 ** E3) + 2);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    logic          v0 = 0, v1 = 0, v2 = 0, v3 = 0;
    logic [N0-1:0] w0 = '0;
    logic [N1-1:0] w1 = '0;
    logic [N2-1:0] w2 = '0;
    logic [N3-1:0] w3 = '0;

    logic ov0, oz0, on0, ov1, oz1, on1, ov2, oz2, on2, ov3, oz3, on3;
    logic [S0-1:0] sc0; logic [N0-E0-1:0] sg0;
    logic [S1-1:0] sc1; logic [N1-E1-1:0] sg1;
    logic [S2-1:0] sc2; logic [N2-E2-1:0] sg2;
    logic [S3-1:0] sc3; logic [N3-E3-1:0] sg3;

    posit_operand_decoder #(.POSIT_W(N0), .EXP_W(E0), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(v0), .in_word(w0), .out_valid(ov0),
        .out_zero(oz0), .out_nar(on0), .out_scale(sc0), .out_sig(sg0));
    posit_operand_decoder #(.POSIT_W(N1), .EXP_W(E1), .REG_OUT(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(v1), .in_word(w1), .out_valid(ov1),
        .out_zero(oz1), .out_nar(on1), .out_scale(sc1), .out_sig(sg1));
    posit_operand_decoder #(.POSIT_W(N2), .EXP_W(E2), .REG_OUT(1'b0)) u2 (
        .clk(clk), .rst_n(rst_n), .in_valid(v2), .in_word(w2), .out_valid(ov2),
        .out_zero(oz2), .out_nar(on2), .out_scale(sc2), .out_sig(sg2));
    posit_operand_decoder #(.POSIT_W(N3), .EXP_W(E3), .REG_OUT(1'b1)) u3 (
        .clk(clk), .rst_n(rst_n), .in_valid(v3), .in_word(w3), .out_valid(ov3),
        .out_zero(oz3), .out_nar(on3), .out_scale(sc3), .out_sig(sg3));

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference: decode the magnitude, then form the signed significand.
    task automatic ref_dec(input logic [31:0] word, input int n, input int es,
                           output bit ez, output bit enr, output bit short_exp,
                           output longint esc, output longint esg);
        logic [63:0] mask, p, m;
        int r0, rl, i, k, idx, e, fb, fbits, pos;
        longint fval, mag, sm;
        mask = (64'd1 << n) - 64'd1;
        p = {32'd0, word} & mask;
        ez = 0; enr = 0; short_exp = 0; esc = 0; esg = 0;
        if (p == 64'd0) begin
            ez = 1;
        end else if (p == (64'd1 << (n - 1))) begin
            enr = 1;
        end else begin
            m = p[n-1] ? ((~p + 64'd1) & mask) : p;
            r0 = int'(m[n-2]);
            rl = 0;
            i = n - 2;
            while (i >= 0 && int'(m[i]) == r0) begin
                rl++;
                i--;
            end
            k = r0 ? rl - 1 : -rl;
            idx = n - 3 - rl;
            e = 0;
            for (int j = 0; j < es; j++) begin
                pos = idx - j;
                e = e * 2 + ((pos >= 0) ? int'(m[pos]) : 0);
                if (pos < 0) short_exp = 1;
            end
            fb = idx + 1 - es;
            if (fb < 0) fb = 0;
            fval = (fb > 0) ? longint'(m & ((64'd1 << fb) - 64'd1)) : 0;
            sm = longint'(k) * (longint'(1) << es) + e;
            fbits = n - es - 2;
            mag = (longint'(1) << fbits) | (fval << (fbits - fb));
            if (!p[n-1]) begin
                esg = mag; esc = sm;
            end else if (fval == 0) begin
                esg = -(longint'(2) << fbits); esc = sm - 1;
            end else begin
                esg = -mag; esc = sm;
            end
            esg = longint'(64'(esg) & ((64'd1 << (n - es)) - 64'd1));
            esc = esc + longint'((n - 2) * (2 ** es) + 1);
        end
    endtask

    task automatic check_dec(input string nm, input int n, input int es, input logic [31:0] word,
                             input logic ov, input logic oz, input logic onr,
                             input longint osc, input longint osg, input bit wide);
        bit ez, enr, sh;
        longint esc, esg;
        string ts, tg;
        ref_dec(word, n, es, ez, enr, sh, esc, esg);
        chk(ov == 1'b1, "R8", {nm, " valid"}, longint'(ov), 1);
        chk(oz == ez, ez ? "R1" : "R3", {nm, " zero flag"}, longint'(oz), longint'(ez));
        chk(onr == enr, enr ? "R2" : "R3", {nm, " nar flag"}, longint'(onr), longint'(enr));
        if (ez || enr) begin
            chk(osc == 0 && osg == 0, ez ? "R1" : "R2", {nm, " cleared scale"}, osc, 0);
        end else begin
            ts = wide ? "R10" : (sh ? "R5" : "R4");
            tg = wide ? "R10" : (word[n-1] ? "R7" : "R6");
            chk(osc == esc, ts, $sformatf("%s scale word=%0h", nm, word), osc, esc);
            chk(osg == esg, tg, $sformatf("%s sig word=%0h", nm, word), osg, esg);
        end
    endtask

    initial begin
        bit ez, enr, sh;
        longint esc, esg;
        logic [31:0] dir [0:8];
        dir[0] = 32'h40000000; dir[1] = 32'h7FFFFFFF; dir[2] = 32'h00000001;
        dir[3] = 32'h80000001; dir[4] = 32'hC0000000; dir[5] = 32'h4ABCDEF1;
        dir[6] = 32'hB5432101; dir[7] = 32'h80000000; dir[8] = 32'h00000000;

        // Reset state of the registered instances (R9)
        repeat (3) @(posedge clk);
        #1;
        chk(ov0 == 0 && oz0 == 0 && on0 == 0, "R9", "u0 reset flags", longint'({ov0, oz0, on0}), 0);
        chk(sc0 == '0 && sg0 == '0, "R9", "u0 reset payload", longint'(sc0), 0);
        chk(ov3 == 0 && sc3 == '0 && sg3 == '0, "R9", "u3 reset", longint'(sc3), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Exhaustive sweeps over the small configurations (R1-style checks per word)
        for (int p = 0; p < 256; p++) begin
            @(negedge clk);
            v0 = 1; v1 = 1; v2 = 1;
            w0 = N0'(p); w1 = N1'(p); w2 = N2'(p);
            @(posedge clk);
            #1;
            check_dec("u0", N0, E0, 32'(w0), ov0, oz0, on0, longint'(sc0), longint'(sg0), 1'b0);
            check_dec("u1", N1, E1, 32'(w1), ov1, oz1, on1, longint'(sc1), longint'(sg1), 1'b0);
            check_dec("u2", N2, E2, 32'(w2), ov2, oz2, on2, longint'(sc2), longint'(sg2), 1'b0);
        end

        // Wide configuration, directed words (R10)
        for (int d = 0; d < 9; d++) begin
            @(negedge clk);
            v3 = 1; w3 = dir[d];
            @(posedge clk);
            #1;
            check_dec("u3", N3, E3, w3, ov3, oz3, on3, longint'(sc3), longint'(sg3), 1'b1);
        end

        // Hold on an idle cycle (R9)
        @(negedge clk);
        v0 = 1; w0 = 8'h5A;
        @(negedge clk);
        v0 = 0; w0 = 8'h33;
        @(posedge clk);
        #1;
        ref_dec(32'h5A, N0, E0, ez, enr, sh, esc, esg);
        chk(ov0 == 0, "R9", "u0 valid low on idle", longint'(ov0), 0);
        chk(longint'(sc0) == esc, "R9", "u0 scale held", longint'(sc0), esc);
        chk(longint'(sg0) == esg, "R9", "u0 sig held", longint'(sg0), esg);

        // Latency: registered instance waits one edge, combinational follows at once (R8)
        @(negedge clk);
        v0 = 1; w0 = 8'h33; v1 = 0;
        #1;
        chk(ov0 == 0, "R8", "u0 valid before edge", longint'(ov0), 0);
        chk(ov1 == 0, "R8", "u1 valid follows input", longint'(ov1), 0);
        @(posedge clk);
        #1;
        ref_dec(32'h33, N0, E0, ez, enr, sh, esc, esg);
        chk(ov0 == 1, "R8", "u0 valid after edge", longint'(ov0), 1);
        chk(longint'(sc0) == esc && longint'(sg0) == esg, "R8", "u0 fields with valid",
            longint'(sc0), esc);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

endmodule